// File: doc/BRIEF.md
# PCI Target First-Phase Latency Guard

This block belongs to the control path of a PCI target. It watches each transaction the target claims and counts bus clocks from the claim until the back end can finish the first data phase. The back end finishes it by having read data ready or by taking write data. If the back end finishes in time, the guard drives TRDY# and the transfer goes ahead. If the budget runs out first, the guard signals Retry: STOP# asserted, TRDY# deasserted. It holds that termination until the master drops FRAME#, then returns to idle. The master later reissues the same request, and the guard treats it as a new transaction with a new budget. This stops a slow back end from holding the bus for an unbounded time.

The budget is 16 clocks for an ordinary target. A strap input raises it to 32 clocks for a host bridge that snoops. The strap is read only while the bus is idle, so a transaction keeps the budget it started with. Two flags go out. A sticky status bit records that a latency timeout caused a Retry, and software clears it by writing a one. A second flag tells the back end that its pending request was retried and will be reissued.

Top module: `pci_lat_guard`

## Requirements
- R1: After reset the block is idle: trdy_n and stop_n are high (deasserted), and lat_timeout_sts and req_retried are 0.
- R2: Counting begins only when frame_n is sampled low together with hit=1. Clock 1 of the transaction is the cycle after that edge. With hit=0, a low frame_n never produces trdy_n or stop_n.
- R3: If be_ready is high in transaction clock k, with k at or below the limit, and no earlier clock had it high, then trdy_n is low and stop_n is high in clock k.
- R4: With the strap low (limit 16), if be_ready has not been high by clock 16, then in clock 16 stop_n is low, trdy_n is high, and retry_pulse is 1.
- R5: With the strap high (limit 32), no Retry occurs before clock 32. If be_ready is still low in clock 32, stop_n goes low in clock 32.
- R6: Once Retry is signalled, stop_n stays low in every following cycle while frame_n is low, including the cycle in which frame_n is first seen high. It is high again in the cycle after that.
- R7: The strap is sampled only while idle. A change during a transaction leaves the limit that was taken at the start unchanged.
- R8: A reissued request after a Retry gets a new count starting at clock 1, so it may again use the full limit.
- R9: Data phases after the first are not timed. Once the first phase has been completed, be_ready may stay low for any number of clocks and stop_n stays high.
- R10: lat_timeout_sts becomes 1 in the cycle after a Retry is issued. It then stays 1 until a cycle with sts_clr=1 (write-one-to-clear). If a Retry and sts_clr=1 occur in the same cycle, the bit is set.
- R11: req_retried becomes 1 in the cycle after a Retry. It returns to 0 in the cycle after a later transaction completes its first phase.
- R12: If the bus goes idle (frame_n and irdy_n both high) while the first phase is pending, the guard returns to idle with no Retry. The next transaction starts a new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME# as seen on the bus, active low |
| irdy_n | input | 1 | IRDY# as seen on the bus, active low |
| hit | input | 1 | Address decode claims the current transaction |
| be_ready | input | 1 | Back end can complete the current data phase |
| snoop_mode | input | 1 | Strap: 1 selects the 32-clock limit for a snooping host bridge |
| sts_clr | input | 1 | Write-one pulse that clears lat_timeout_sts |
| trdy_n | output | 1 | TRDY# drive request, active low |
| stop_n | output | 1 | STOP# drive request, active low |
| retry_pulse | output | 1 | High in the clock in which a latency Retry is issued |
| lat_timeout_sts | output | 1 | Sticky flag: a latency Retry has occurred |
| req_retried | output | 1 | Pending back-end request was retried and will return |

## Verification
The main stimulus sweeps the back end's ready clock from 1 to two clocks past the limit, under both strap settings. This separates a transfer completed on the last allowed clock from a Retry on that clock, and confirms that no early STOP# appears at 16 clocks in snooping mode. Further runs flip the strap during a transaction, reissue a request directly after a Retry or after an aborted transaction, and stall a later data phase for much longer than either limit. These show that the budget is latched once per transaction, starts again from clock 1, and covers only the first phase. The status clear is tried alone and in the same cycle as a new timeout, which shows that setting wins over clearing.

// File: rtl/pci_lg_pkg.sv
package pci_lg_pkg;

  typedef enum logic [1:0] {
    LG_IDLE  = 2'd0,
    LG_WAIT  = 2'd1,
    LG_DATA  = 2'd2,
    LG_RETRY = 2'd3
  } lg_state_e;

  // Budget in clocks chosen by the strap.
  function automatic int unsigned budget_of(input logic snoop,
                                            input int unsigned base_clks,
                                            input int unsigned snoop_clks);
    return snoop ? snoop_clks : base_clks;
  endfunction

  // Bus is idle when neither FRAME# nor IRDY# is asserted.
  function automatic logic bus_is_idle(input logic frame_n, input logic irdy_n);
    return frame_n & irdy_n;
  endfunction

endpackage

// File: rtl/lg_budget.sv
module lg_budget #(
  parameter int unsigned BASE_LIMIT  = 16,
  parameter int unsigned SNOOP_LIMIT = 32,
  parameter int unsigned CW          = $clog2(SNOOP_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_idle,
  input  logic          start,
  input  logic          advance,
  input  logic          snoop_mode,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] limit,
  output logic          at_limit
);
  import pci_lg_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit_q;
  logic [CW-1:0] limit_sel;

  assign limit_sel = CW'(budget_of(snoop_mode, BASE_LIMIT, SNOOP_LIMIT));

  // The strap is taken only while idle; the start edge is an idle edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       limit_q <= CW'(BASE_LIMIT);
    else if (in_idle) limit_q <= limit_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start)   cnt_q <= ONE;
    else if (advance) cnt_q <= cnt_q + ONE;
    else if (in_idle) cnt_q <= '0;
  end

  assign cnt      = cnt_q;
  assign limit    = limit_q;
  assign at_limit = (cnt_q == limit_q);

  // R4 R5: count never passes the latched budget
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_q);

  // R7: budget only moves on idle edges
  p_limit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> $stable(limit_q));

  // R8: a new transaction restarts at clock 1
  p_fresh_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == ONE));

endmodule

// File: rtl/lg_fsm.sv
module lg_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic                  hit,
  input  logic                  be_ready,
  input  logic                  at_limit,
  output pci_lg_pkg::lg_state_e state,
  output logic                  in_idle,
  output logic                  start,
  output logic                  advance,
  output logic                  retry_evt,
  output logic                  first_done,
  output logic                  trdy_n,
  output logic                  stop_n
);
  import pci_lg_pkg::*;

  lg_state_e st_q, st_d;
  logic      idle_bus;
  logic      in_wait;
  logic      live_wait;

  assign idle_bus  = bus_is_idle(frame_n, irdy_n);
  assign in_idle   = (st_q == LG_IDLE);
  assign in_wait   = (st_q == LG_WAIT);
  assign live_wait = in_wait & ~idle_bus;

  // Named internal events
  assign start      = in_idle & ~frame_n & hit;
  assign first_done = live_wait & be_ready;
  assign retry_evt  = live_wait & ~be_ready & at_limit;
  assign advance    = live_wait & ~be_ready & ~at_limit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LG_IDLE:  if (start) st_d = LG_WAIT;
      LG_WAIT: begin
        if (idle_bus)        st_d = LG_IDLE;
        else if (be_ready)   st_d = LG_DATA;
        else if (at_limit)   st_d = LG_RETRY;
      end
      LG_DATA:  if (idle_bus) st_d = LG_IDLE;
      LG_RETRY: if (frame_n)  st_d = LG_IDLE;
      default:  st_d = LG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LG_IDLE;
    else        st_q <= st_d;
  end

  assign state  = st_q;
  assign trdy_n = ~(((st_q == LG_WAIT) | (st_q == LG_DATA)) & be_ready);
  assign stop_n = ~((st_q == LG_RETRY) | retry_evt);

  // R3: TRDY# and STOP# never asserted together
  p_one_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(~trdy_n & ~stop_n));

  // R6: STOP# persists while FRAME# is still asserted
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (~stop_n & ~frame_n) |=> ~stop_n);

  // R6: once FRAME# is seen high during Retry, idle follows
  p_retry_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == LG_RETRY) & frame_n) |=> (st_q == LG_IDLE));

  // R9: later data phases never lead to STOP#
  p_no_late_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LG_DATA) |-> stop_n);

  // R2: no transaction without a decode hit
  p_need_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle & ~hit) |=> (st_q == LG_IDLE));

endmodule

// File: rtl/lg_flags.sv
module lg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic retry_evt,
  input  logic first_done,
  input  logic sts_clr,
  output logic sts,
  output logic retried
);

  logic sts_q;
  logic retried_q;

  // Set has priority over the write-one clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sts_q <= 1'b0;
    else if (retry_evt) sts_q <= 1'b1;
    else if (sts_clr)   sts_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          retried_q <= 1'b0;
    else if (retry_evt)  retried_q <= 1'b1;
    else if (first_done) retried_q <= 1'b0;
  end

  assign sts     = sts_q;
  assign retried = retried_q;

  // R10: timeout always leaves the sticky bit set
  p_sts_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> sts_q);

  // R10: without a clear the bit does not fall
  p_sts_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~sts_clr) |=> sts_q);

  // R11: completing a first phase drops the retried flag
  p_retried_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    first_done |=> ~retried_q);

endmodule

// File: rtl/pci_lat_guard.sv
module pci_lat_guard #(
  parameter int unsigned BASE_LIMIT  = 16,
  parameter int unsigned SNOOP_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit,
  input  logic be_ready,
  input  logic snoop_mode,
  input  logic sts_clr,
  output logic trdy_n,
  output logic stop_n,
  output logic retry_pulse,
  output logic lat_timeout_sts,
  output logic req_retried
);
  import pci_lg_pkg::*;

  localparam int unsigned CW = $clog2(SNOOP_LIMIT + 1);

  lg_state_e     state;
  logic          in_idle;
  logic          start;
  logic          advance;
  logic          retry_evt;
  logic          first_done;
  logic          at_limit;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  lg_budget #(
    .BASE_LIMIT (BASE_LIMIT),
    .SNOOP_LIMIT(SNOOP_LIMIT),
    .CW         (CW)
  ) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_idle   (in_idle),
    .start     (start),
    .advance   (advance),
    .snoop_mode(snoop_mode),
    .cnt       (cnt),
    .limit     (limit),
    .at_limit  (at_limit)
  );

  lg_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .hit       (hit),
    .be_ready  (be_ready),
    .at_limit  (at_limit),
    .state     (state),
    .in_idle   (in_idle),
    .start     (start),
    .advance   (advance),
    .retry_evt (retry_evt),
    .first_done(first_done),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n)
  );

  lg_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .retry_evt (retry_evt),
    .first_done(first_done),
    .sts_clr   (sts_clr),
    .sts       (lat_timeout_sts),
    .retried   (req_retried)
  );

  assign retry_pulse = retry_evt;

  // R4 R5: a Retry only fires at the latched budget
  p_retry_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |-> (cnt == limit));

  // R12: waiting state is left when the bus idles
  p_abort_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == LG_WAIT) & frame_n & irdy_n) |=> (state == LG_IDLE));

endmodule

// File: tb/sim_pci_lat_guard.sv
module sim_pci_lat_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, hit = 1'b0, be_ready = 1'b0;
  logic snoop_mode = 1'b0, sts_clr = 1'b0;
  logic trdy_n, stop_n, retry_pulse, lat_timeout_sts, req_retried;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pci_lat_guard u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .hit(hit),
    .be_ready(be_ready), .snoop_mode(snoop_mode), .sts_clr(sts_clr),
    .trdy_n(trdy_n), .stop_n(stop_n), .retry_pulse(retry_pulse),
    .lat_timeout_sts(lat_timeout_sts), .req_retried(req_retried)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pack outputs {trdy_n, stop_n} for compact comparison
  function automatic int term();
    return {30'd0, trdy_n, stop_n};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  // One transaction; ready first seen in clock d; mode is the strap at start.
  task automatic run_txn(input bit mode, input int d, input bit flip);
    int  lim = mode ? 32 : 16;
    bit  done = 1'b0;
    cyc(); frame_n = 1'b0; hit = 1'b1; irdy_n = 1'b1; be_ready = 1'b0; snoop_mode = mode;
    #1 chk(term() == 3, "R2 idle before start", term(), 3);
    for (int k = 1; k <= lim && !done; k++) begin
      cyc(); hit = 1'b0; irdy_n = 1'b0; be_ready = (k >= d);
      if (flip) snoop_mode = ~mode;
      #1;
      if (k >= d) begin
        chk(term() == 1, "R3 trdy at ready clock", term(), 1);
        done = 1'b1;
      end else if (k == lim) begin
        chk(term() == 2, mode ? "R5 stop at clock 32" : "R4 stop at clock 16", term(), 2);
        chk(retry_pulse == 1'b1, "R4 retry pulse", retry_pulse, 1);
      end else begin
        chk(term() == 3, mode ? "R5 no early stop" : "R2 counting quiet", term(), 3);
      end
    end
    if (done) begin
      cyc(); frame_n = 1'b1; irdy_n = 1'b0; be_ready = 1'b1;
      #1 chk(req_retried == 1'b0, "R11 retried cleared", req_retried, 0);
      cyc(); irdy_n = 1'b1; be_ready = 1'b0;
      #1 chk(term() == 3, "R1 idle after transfer", term(), 3);
    end else begin
      cyc(); be_ready = 1'b0;
      #1 chk(stop_n == 1'b0, "R6 stop held", stop_n, 0);
      chk(lat_timeout_sts == 1'b1, "R10 sticky set", lat_timeout_sts, 1);
      chk(req_retried == 1'b1, "R11 retried set", req_retried, 1);
      cyc(); frame_n = 1'b1;
      #1 chk(stop_n == 1'b0, "R6 stop on frame release", stop_n, 0);
      cyc(); irdy_n = 1'b1;
      #1 chk(term() == 3, "R6 idle after retry", term(), 3);
    end
    snoop_mode = mode;
  endtask

  initial begin
    #1;
    chk(term() == 3, "R1 reset terms", term(), 3);
    chk(lat_timeout_sts == 1'b0, "R1 reset sts", lat_timeout_sts, 0);
    chk(req_retried == 1'b0, "R1 reset retried", req_retried, 0);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R3 R4 R5: sweep ready clock across both limits
    for (int m = 0; m < 2; m++)
      for (int d = 1; d <= (m ? 34 : 18); d++)
        run_txn(m[0], d, 1'b0);

    // R2: frame without a decode hit
    cyc(); frame_n = 1'b0; hit = 1'b0; irdy_n = 1'b0;
    for (int k = 0; k < 40; k++) begin
      cyc(); #1 chk(term() == 3, "R2 no hit no terms", term(), 3);
    end
    cyc(); frame_n = 1'b1; irdy_n = 1'b1;
    cyc();

    // R7: strap flips mid-transaction, both directions
    run_txn(1'b0, 40, 1'b1);
    run_txn(1'b1, 31, 1'b1);
    run_txn(1'b1, 40, 1'b1);

    // R8: reissue right after Retry gets the full budget again
    run_txn(1'b0, 17, 1'b0);
    run_txn(1'b0, 16, 1'b0);

    // R10: write-one clear, then clear colliding with a new Retry
    cyc(); sts_clr = 1'b1;
    cyc(); sts_clr = 1'b0;
    #1 chk(lat_timeout_sts == 1'b0, "R10 cleared by write one", lat_timeout_sts, 0);
    cyc(); frame_n = 1'b0; hit = 1'b1; snoop_mode = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      cyc(); hit = 1'b0; irdy_n = 1'b0; sts_clr = (k == 16);
    end
    cyc(); sts_clr = 1'b0;
    #1 chk(lat_timeout_sts == 1'b1, "R10 set wins over clear", lat_timeout_sts, 1);
    frame_n = 1'b1;
    cyc(); irdy_n = 1'b1;
    cyc();

    // R12: abort mid-wait, then fresh full count
    cyc(); frame_n = 1'b0; hit = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      cyc(); hit = 1'b0; irdy_n = 1'b0;
    end
    cyc(); frame_n = 1'b1; irdy_n = 1'b1;
    #1 chk(retry_pulse == 1'b0, "R12 no retry on abort", retry_pulse, 0);
    cyc();
    #1 chk(term() == 3, "R12 idle after abort", term(), 3);
    run_txn(1'b0, 16, 1'b0);

    // R9: long stall in a later data phase
    cyc(); frame_n = 1'b0; hit = 1'b1;
    cyc(); hit = 1'b0; irdy_n = 1'b0; be_ready = 1'b1;
    #1 chk(term() == 1, "R9 first phase done", term(), 1);
    for (int k = 0; k < 50; k++) begin
      cyc(); be_ready = 1'b0;
      #1 chk(stop_n == 1'b1, "R9 no stop in later phase", stop_n, 1);
    end
    cyc(); be_ready = 1'b1; frame_n = 1'b1;
    #1 chk(trdy_n == 1'b0, "R9 later phase completes", trdy_n, 0);
    cyc(); irdy_n = 1'b1; be_ready = 1'b0;
    cyc();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule